// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the device-side engine of a two-wire program/verify port. The core clock samples an external serial clock line and a serial data line. Commands are six bits long. After a load or read command comes a sixteen-clock data segment. The block keeps an eleven-bit address counter and turns decoded commands into one-cycle strobes on a simple word-wide memory port. A separate level input, `mode_en`, stands for the detection of the programming voltage. While it is low, the block is held in its entry state. When it rises, programming starts from a clean state.

Both serial lines go through a synchronizer. Edges of the serial clock become single-cycle rise and fall events. Bits are captured on falling edges, and the block drives the data line only when its output enable is high. A read returns the memory word at the current address. A load writes the captured word to the current address once the segment is complete. The remaining commands produce strobes for the memory controller, which owns the cell timing.

Top module: `serprog_tgt`

## Requirements
- R1: A command is six serial-clock cycles. One bit is captured at each falling edge, least significant bit first. The recognised codes are load 0x02, read 0x04, increment 0x06, begin-programming 0x08, end-programming 0x0E and bulk-erase 0x09.
- R2: While `mode_en` is low, the address stays at 0x7FF, all command and segment progress is discarded, no strobe fires and the data output enable is low. A partial command is therefore lost when the mode drops.
- R3: The increment command adds one to the address, which wraps from 0x7FF to 0x000. So the first increment after entry selects address 0.
- R4: A load is followed by a 16-clock segment. The falling edges of data clocks 2 to 15 carry a 14-bit word, least significant bit first. The values at data clocks 1 and 16 are ignored. After the 16th falling edge, `mem_load` pulses for one cycle, with the low 12 bits of the word on `mem_wdata` at the current address.
- R5: During a read segment, `ser_dat_oe` rises at the rising edge of data clock 2 and falls at the rising edge of data clock 16. It is low at all other times, and `ser_dat_out` is low whenever the enable is low.
- R6: A read returns the `mem_rdata` word present when the command completes. Word bit k is driven from the rising edge of data clock k+2, and bits 12 and 13 are driven as zero.
- R7: Begin-programming, end-programming and bulk-erase each produce exactly one single-cycle strobe on their own output. At most one memory strobe is high in any cycle.
- R8: An unrecognised six-bit code has no effect on the address or the memory port, and the next six clocks are taken as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Programming mode present; low holds entry state |
| ser_clk | input | 1 | Serial clock line (asynchronous) |
| ser_dat_in | input | 1 | Serial data line, input side |
| ser_dat_out | output | 1 | Serial data line, output value |
| ser_dat_oe | output | 1 | Serial data line output enable |
| mem_addr | output | 11 | Current word address |
| mem_wdata | output | 12 | Word to write on a load strobe |
| mem_rdata | input | 12 | Word stored at `mem_addr` |
| mem_load | output | 1 | One-cycle write strobe |
| mem_prog_begin | output | 1 | One-cycle begin-programming strobe |
| mem_prog_end | output | 1 | One-cycle end-programming strobe |
| mem_erase | output | 1 | One-cycle bulk-erase strobe |

## Verification
The first load is sent with its framing bits set to one and a word that has both upper bits set. A design that captures the start or stop slot, or that keeps the wrong twelve bits, therefore writes a different word. The second load uses framing bits of zero and a different bit pattern. Reads follow each load and also hit an address that was never loaded, which separates the write path from the bench's preset contents. The output enable is checked in every one of the sixteen data clocks. Unrecognised codes are followed by an increment, and a command cut off by a mode drop is followed by one. This shows whether a stale bit count survived, because a surviving count would misframe the next command.

// File: rtl/serprog_pkg.sv
// Shared constants for the serial programming target.
// Assumes a fixed six-bit command word; the codes below are the only ones decoded.
package serprog_pkg;
    localparam int CW = 6;

    typedef enum logic [CW-1:0] {
        CMD_LOAD  = 6'h02,
        CMD_READ  = 6'h04,
        CMD_INC   = 6'h06,
        CMD_PBEG  = 6'h08,
        CMD_PEND  = 6'h0E,
        CMD_ERASE = 6'h09
    } cmd_e;
endpackage

// File: rtl/serprog_edge.sv
// Synchronizes the serial clock and data lines into the core clock domain and
// turns serial-clock transitions into single-cycle rise/fall events.
// Assumes SYNC >= 2 and a serial clock far slower than clk. Data runs through
// the same depth as the clock, so a sampled bit lines up with its edge.
module serprog_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_clk,
    input  logic pin_dat,
    output logic rise,
    output logic fall,
    output logic dat_s
);
    logic [SYNC-1:0] csync;
    logic [SYNC-1:0] dsync;
    logic            cprev;

    // Shift both lines through the synchronizer stages and remember the last clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csync <= '0;
            dsync <= '0;
            cprev <= 1'b0;
        end else begin
            csync <= {csync[SYNC-2:0], pin_clk};
            dsync <= {dsync[SYNC-2:0], pin_dat};
            cprev <= csync[SYNC-1];
        end
    end

    assign rise  = csync[SYNC-1] & ~cprev;
    assign fall  = ~csync[SYNC-1] & cprev;
    assign dat_s = dsync[SYNC-1];
endmodule

// File: rtl/serprog_addr.sv
// Word address counter: preset to all ones while cleared, wraps on increment.
// Assumes clear and inc are never meaningful in the same cycle; clear wins.
module serprog_addr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    // Hold the entry address while cleared, otherwise step by one on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr <= '1;
        end else if (inc) begin
            addr <= addr + AW'(1);
        end
    end
endmodule

// File: rtl/serprog_frame.sv
// Runs one data segment of DW+2 serial clocks: the first and last clocks are
// framing slots and the DW clocks between them carry the word, LSB first.
// Input bits are taken on falling edges. On a read, output bits change on
// rising edges and the enable covers rising edges 2 .. DW+1 exclusive of the stop.
// Assumes start is a single-cycle pulse that comes only while idle.
module serprog_frame #(
    parameter int DW = 14,
    parameter int MW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          start,
    input  logic          start_read,
    input  logic [DW-1:0] rword,
    input  logic          rise,
    input  logic          fall,
    input  logic          dat,
    output logic          busy,
    output logic          done,
    output logic [MW-1:0] word_lo,
    output logic          dout,
    output logic          oe
);
    localparam int FR   = DW + 2;
    localparam int CNTW = $clog2(FR + 1);
    localparam logic [CNTW-1:0] C_FIRST = CNTW'(2);
    localparam logic [CNTW-1:0] C_LAST  = CNTW'(FR - 1);
    localparam logic [CNTW-1:0] C_END   = CNTW'(FR);

    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] cnt_nxt;
    logic            is_read;
    logic [DW-1:0]   sh_in;
    logic [DW-1:0]   sh_out;

    assign cnt_nxt = cnt + CNTW'(1);

    // Count segment clocks, shift input bits in and output bits out.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            is_read <= 1'b0;
            cnt     <= '0;
            sh_in   <= '0;
            sh_out  <= '0;
            dout    <= 1'b0;
            oe      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                is_read <= start_read;
                cnt     <= '0;
                sh_out  <= rword;
            end else if (busy) begin
                if (rise) begin
                    cnt <= cnt_nxt;
                    if (is_read && cnt_nxt >= C_FIRST && cnt_nxt <= C_LAST) begin
                        oe     <= 1'b1;
                        dout   <= sh_out[0];
                        sh_out <= sh_out >> 1;
                    end else if (cnt_nxt == C_END) begin
                        oe   <= 1'b0;
                        dout <= 1'b0;
                    end
                end
                if (fall) begin
                    if (cnt >= C_FIRST && cnt <= C_LAST) begin
                        sh_in <= {dat, sh_in[DW-1:1]};
                    end
                    if (cnt == C_END) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

    assign word_lo = sh_in[MW-1:0];
endmodule

// File: rtl/serprog_tgt.sv
// Top of the serial programming target: command shifter, decoder and memory
// strobes around the synchronizer, address counter and data segment engine.
// Assumes mode_en is already a clean level in the clk domain and that the
// serial clock is low when mode_en rises.
module serprog_tgt
    import serprog_pkg::*;
#(
    parameter int AW   = 11,
    parameter int MW   = 12,
    parameter int DW   = 14,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic          ser_clk,
    input  logic          ser_dat_in,
    output logic          ser_dat_out,
    output logic          ser_dat_oe,
    output logic [AW-1:0] mem_addr,
    output logic [MW-1:0] mem_wdata,
    input  logic [MW-1:0] mem_rdata,
    output logic          mem_load,
    output logic          mem_prog_begin,
    output logic          mem_prog_end,
    output logic          mem_erase
);
    localparam int CCW = $clog2(CW);
    localparam logic [CCW-1:0] C_LASTBIT = CCW'(CW - 1);

    logic           rise, fall, dat_s;
    logic           clear;
    logic [CW-1:0]  cmd_sr;
    logic [CW-1:0]  code;
    logic [CCW-1:0] cmd_cnt;
    logic           cmd_done;
    logic           seg_busy, seg_done, seg_load;
    logic           start_load, start_read, do_inc;

    assign clear = ~mode_en;

    serprog_edge #(.SYNC(SYNC)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_clk (ser_clk),
        .pin_dat (ser_dat_in),
        .rise    (rise),
        .fall    (fall),
        .dat_s   (dat_s)
    );

    // Next command value if this falling edge shifts in a bit; completion on the sixth.
    assign code     = {dat_s, cmd_sr[CW-1:1]};
    assign cmd_done = fall & ~seg_busy & (cmd_cnt == C_LASTBIT);

    assign start_load = cmd_done & (code == CMD_LOAD);
    assign start_read = cmd_done & (code == CMD_READ);
    assign do_inc     = cmd_done & (code == CMD_INC);

    // Shift command bits in LSB first and count them while no segment runs.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cmd_sr  <= '0;
            cmd_cnt <= '0;
        end else if (fall && !seg_busy) begin
            cmd_sr  <= code;
            cmd_cnt <= (cmd_cnt == C_LASTBIT) ? '0 : cmd_cnt + CCW'(1);
        end
    end

    serprog_addr #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .inc   (do_inc),
        .addr  (mem_addr)
    );

    serprog_frame #(.DW(DW), .MW(MW)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .start      (start_load | start_read),
        .start_read (start_read),
        .rword      ({{(DW-MW){1'b0}}, mem_rdata}),
        .rise       (rise),
        .fall       (fall),
        .dat        (dat_s),
        .busy       (seg_busy),
        .done       (seg_done),
        .word_lo    (mem_wdata),
        .dout       (ser_dat_out),
        .oe         (ser_dat_oe)
    );

    // Remember segment type and issue one-cycle memory strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seg_load       <= 1'b0;
            mem_load       <= 1'b0;
            mem_prog_begin <= 1'b0;
            mem_prog_end   <= 1'b0;
            mem_erase      <= 1'b0;
        end else begin
            if (cmd_done) begin
                seg_load <= start_load;
            end
            mem_load       <= seg_done & seg_load;
            mem_prog_begin <= cmd_done & (code == CMD_PBEG);
            mem_prog_end   <= cmd_done & (code == CMD_PEND);
            mem_erase      <= cmd_done & (code == CMD_ERASE);
        end
    end
endmodule

// File: rtl/serprog_chk.sv
// Protocol checker for serprog_tgt, attached through bind.
// Assumes only the top-level ports; it watches entry state, strobes and the address.
module serprog_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_en,
    input logic          ser_dat_out,
    input logic          ser_dat_oe,
    input logic [AW-1:0] mem_addr,
    input logic          mem_load,
    input logic          mem_prog_begin,
    input logic          mem_prog_end,
    input logic          mem_erase
);
    // Outside the mode the address sits at its entry value.
    p_entry_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (mem_addr == '1));

    // Outside the mode nothing is driven and nothing is strobed.
    p_entry_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (!ser_dat_oe && !mem_load && !mem_prog_begin && !mem_prog_end && !mem_erase));

    // Within the mode the address only ever steps by one.
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && $past(mode_en) && (mem_addr != $past(mem_addr)))
        |-> (mem_addr == $past(mem_addr) + AW'(1)));

    // The data output is low whenever the pin is not driven.
    p_dout_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_dat_oe |-> !ser_dat_out);

    // Never more than one memory strobe at a time.
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_load, mem_prog_begin, mem_prog_end, mem_erase}));

    // Every strobe lasts a single cycle.
    p_short_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_load || mem_prog_begin || mem_prog_end || mem_erase)
        |=> !(mem_load || mem_prog_begin || mem_prog_end || mem_erase));
endmodule

bind serprog_tgt serprog_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_en        (mode_en),
    .ser_dat_out    (ser_dat_out),
    .ser_dat_oe     (ser_dat_oe),
    .mem_addr       (mem_addr),
    .mem_load       (mem_load),
    .mem_prog_begin (mem_prog_begin),
    .mem_prog_end   (mem_prog_end),
    .mem_erase      (mem_erase)
);

// File: tb/serprog_tgt_tb.sv
// Scoreboard bench: command tasks queue the strobes they expect, a monitor
// pops and compares them as the design raises strobes; reads are checked inline.
module serprog_tgt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_en = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat_in = 1'b0;
    logic        ser_dat_out, ser_dat_oe;
    logic [10:0] mem_addr;
    logic [11:0] mem_wdata, mem_rdata;
    logic        mem_load, mem_prog_begin, mem_prog_end, mem_erase;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct packed {
        logic [1:0]  kind;   // 0 load, 1 begin, 2 end, 3 erase
        logic [10:0] addr;
        logic [11:0] data;
    } item_t;
    item_t sbq[$];

    logic [11:0] mem     [2048];
    logic [11:0] exp_mem [2048];
    logic [10:0] exp_addr;

    always #2 clk = ~clk;

    serprog_tgt u_dut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
        .ser_clk(ser_clk), .ser_dat_in(ser_dat_in),
        .ser_dat_out(ser_dat_out), .ser_dat_oe(ser_dat_oe),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_load(mem_load), .mem_prog_begin(mem_prog_begin),
        .mem_prog_end(mem_prog_end), .mem_erase(mem_erase)
    );

    function automatic logic [11:0] preset(input int a);
        return 12'((a * 37) ^ 12'h5A5);
    endfunction

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) if (mem_load) mem[mem_addr] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every strobe with the head of the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && (mem_load | mem_prog_begin | mem_prog_end | mem_erase)) begin
            logic [1:0] k;
            item_t      it;
            k = mem_load ? 2'd0 : mem_prog_begin ? 2'd1 : mem_prog_end ? 2'd2 : 2'd3;
            if (sbq.size() == 0) begin
                chk(0, "R8 unexpected strobe", int'(k), -1);
            end else begin
                it = sbq.pop_front();
                chk(it.kind == k && it.addr == mem_addr &&
                    (k != 2'd0 || it.data == mem_wdata),
                    (k == 2'd0) ? "R4 load strobe" : "R7 strobe",
                    int'({k, mem_addr, mem_wdata}), int'({it.kind, it.addr, it.data}));
            end
        end
    end

    task automatic pulse(input logic b);
        ser_dat_in = b;
        repeat (5) @(negedge clk);
        ser_clk = 1'b1;
        repeat (10) @(negedge clk);
        ser_clk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_rd(output logic oe_s, output logic d_s);
        ser_dat_in = 1'b0;
        repeat (5) @(negedge clk);
        ser_clk = 1'b1;
        repeat (8) @(negedge clk);
        oe_s = ser_dat_oe;
        d_s  = ser_dat_out;
        repeat (2) @(negedge clk);
        ser_clk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [5:0] c);
        for (int i = 0; i < 6; i++) pulse(c[i]);
        repeat (10) @(negedge clk);
    endtask

    task automatic enter();
        mode_en = 1'b0;
        repeat (6) @(negedge clk);
        mode_en = 1'b1;
        repeat (6) @(negedge clk);
        exp_addr = 11'h7FF;
    endtask

    task automatic do_inc(input string req);
        send_cmd(6'h06);
        exp_addr = exp_addr + 11'd1;
        chk(mem_addr == exp_addr, req, int'(mem_addr), int'(exp_addr));
    endtask

    task automatic do_load(input logic [13:0] w, input logic frame_bit);
        sbq.push_back('{kind: 2'd0, addr: exp_addr, data: w[11:0]});
        send_cmd(6'h02);
        pulse(frame_bit);
        for (int i = 0; i < 14; i++) pulse(w[i]);
        pulse(frame_bit);
        repeat (10) @(negedge clk);
        exp_mem[exp_addr] = w[11:0];
    endtask

    task automatic do_read();
        logic [13:0] word;
        logic        o, d;
        bit          oe_ok;
        word  = '0;
        oe_ok = 1;
        send_cmd(6'h04);
        for (int k = 1; k <= 16; k++) begin
            pulse_rd(o, d);
            if (o != ((k >= 2) && (k <= 15))) oe_ok = 0;
            if (k >= 2 && k <= 15) word[k-2] = d;
        end
        repeat (10) @(negedge clk);
        chk(oe_ok, "R5 enable window", int'(oe_ok), 1);
        chk(word == {2'b00, exp_mem[exp_addr]}, "R6 read word",
            int'(word), int'({2'b00, exp_mem[exp_addr]}));
        chk(!ser_dat_oe, "R5 released after read", int'(ser_dat_oe), 0);
    endtask

    task automatic do_strobe(input logic [5:0] c, input logic [1:0] k);
        sbq.push_back('{kind: k, addr: exp_addr, data: 12'h000});
        send_cmd(c);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 2048; a++) begin
            mem[a]     = preset(a);
            exp_mem[a] = preset(a);
        end
        exp_addr = 11'h7FF;
        repeat (8) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!ser_dat_oe, "R2 reset enable low", int'(ser_dat_oe), 0);
        chk(mem_addr == 11'h7FF, "R2 reset address", int'(mem_addr), 'h7FF);

        enter();
        chk(mem_addr == 11'h7FF, "R2 entry address", int'(mem_addr), 'h7FF);

        do_inc("R3 wrap to zero");          // 0x7FF -> 0x000
        do_load(14'h3ABC, 1'b1);            // R4 framing bits set, upper bits set
        do_read();                          // R6 expect 0x0ABC
        do_inc("R3 step to one");
        do_read();                          // R6 preset word, never loaded
        do_load(14'h0155, 1'b0);            // R4 different pattern
        do_read();

        do_strobe(6'h08, 2'd1);             // R7 begin programming
        do_strobe(6'h0E, 2'd2);             // R7 end programming
        do_strobe(6'h09, 2'd3);             // R7 bulk erase

        send_cmd(6'h3F);                    // R8 unknown codes
        send_cmd(6'h00);
        chk(mem_addr == exp_addr, "R8 address kept", int'(mem_addr), int'(exp_addr));
        do_inc("R8 next command framed");

        pulse(1'b0); pulse(1'b1); pulse(1'b1);  // R2 partial command, then mode drop
        enter();
        chk(mem_addr == 11'h7FF, "R2 re-entry address", int'(mem_addr), 'h7FF);
        do_inc("R1 fresh framing after re-entry");
        do_read();                          // R1 read at address 0 after re-entry

        repeat (20) @(negedge clk);
        chk(sbq.size() == 0, "R7 all expected strobes seen", sbq.size(), 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule